// File: doc/BRIEF.md
# SMP Private Region Register Decoder

This block fronts the private peripheral window of a small multiprocessor cluster. The window is 0x2000 bytes. A single register-bus request carries a byte offset into the window. The block turns it into exactly one target select, or into a decode error. The targets are the snoop-control registers, the interrupt CPU interfaces, the per-CPU timer and watchdog windows, and the interrupt distributor.

The snoop-control registers live inside the block, in the first 0x100 bytes of the window. They are control, configuration, CPU status and invalidate-all. An access to them, or an access that decodes to nothing, is answered by the block itself one cycle later. An access that decodes to an external target only raises that target's select in the same cycle. The target produces its own response.

Each interface family has an alias slot for "the requesting CPU" ahead of the per-CPU slots. The interface and timer/watchdog selects are therefore vectors of NUM_CPU+1 bits. Bit 0 is the alias and bit i+1 is CPU i. NUM_CPU ranges from 1 to 4.

Top module: `smp_priv_decode`

## Requirements
- R1: After reset the control register reads 0 and no response is pending (rsp_valid_o low).
- R2: A write to offset 0x00 keeps only bit 0 of the data. A later read of 0x00 returns that bit in bit 0 with all other bits zero.
- R3: A read of offset 0x04 returns ones in bits 4 to 4+NUM_CPU-1 and NUM_CPU-1 in the low bits. With NUM_CPU=4 this is 0xF3.
- R4: Reads of offset 0x08 and 0x0C return 0. A write to 0x0C has no effect on the control register and is not an error.
- R5: These accesses raise rsp_err_o with rsp_rdata_o zero and leave the control register unchanged: any other offset in 0x000-0x0FF, and any write to 0x04 or 0x08.
- R6: Offsets 0x100 + s*0x100, for s from 0 to NUM_CPU, raise sel_cpuif_o[s]. Slot 0 (0x100) is the requesting-CPU alias, and slot c+1 belongs to CPU c.
- R7: Within page 0x600 + s*0x100, for s from 0 to NUM_CPU, offsets 0x00-0x1F raise sel_timer_o[s] and offsets 0x20-0x3F raise sel_wdog_o[s]. The rest of such a page is a decode error.
- R8: Every offset from 0x1000 to 0x1FFF raises sel_dist_o.
- R9: An offset in no populated slot raises the error and no select. This includes interface or timer pages beyond the configured CPU count and pages 0xB00-0xFFF.
- R10: At most one select is high, and only while req_valid_i is high. req_ready_o is always high. A locally answered access (snoop-control or error) produces rsp_valid_o exactly one cycle later; a forwarded access produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte offset in the window, bits 1:0 ignored |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Local response valid |
| rsp_rdata_o | output | 32 | Local read data |
| rsp_err_o | output | 1 | Local response is a decode/access error |
| sel_scu_o | output | 1 | Snoop-control register access |
| sel_cpuif_o | output | NUM_CPU+1 | Interrupt CPU interface slot select |
| sel_timer_o | output | NUM_CPU+1 | Timer window slot select |
| sel_wdog_o | output | NUM_CPU+1 | Watchdog window slot select |
| sel_dist_o | output | 1 | Interrupt distributor select |

## Verification
The hardest cases to observe are the ones that must leave state untouched. These are a write to invalidate-all, and writes to the read-only configuration or status offsets. Their only trace is the control register. The bench therefore first sets the control bit to 1, issues each such write, and reads the control register back before any other write. It then walks the page boundaries: the last alias byte, the first watchdog byte, the hole after the watchdog window, and the pages beyond the last timer slot.

// File: rtl/smp_priv_pkg.sv
package smp_priv_pkg;
  localparam int unsigned WIN_AW = 13;
  localparam int unsigned DW     = 32;

  typedef enum logic [2:0] {
    TGT_ERR, TGT_SCU, TGT_CPUIF, TGT_TIMER, TGT_WDOG, TGT_DIST
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] slot;
  } dec_t;

  function automatic logic [DW-1:0] cfg_value(int unsigned n);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < 4; i++) if (i < int'(n)) v[4+i] = 1'b1;
    v[1:0] = 2'(n - 1);
    return v;
  endfunction
endpackage

// File: rtl/smp_addr_decode.sv
module smp_addr_decode
  import smp_priv_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic [WIN_AW-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int unsigned SLOTS = NUM_CPU + 1;
  localparam logic [3:0] CPUIF_LAST = 4'(SLOTS);
  localparam logic [3:0] TMR_FIRST  = 4'd6;
  localparam logic [3:0] TMR_LAST   = 4'(5 + SLOTS);

  logic [3:0] page;
  logic [2:0] sub;
  assign page = addr_i[11:8];
  assign sub  = addr_i[7:5];

  always_comb begin
    dec_o.tgt  = TGT_ERR;
    dec_o.slot = '0;
    if (addr_i[12]) begin
      dec_o.tgt = TGT_DIST;
    end else if (page == 4'd0) begin
      dec_o.tgt = TGT_SCU;
    end else if (page <= CPUIF_LAST) begin
      dec_o.tgt  = TGT_CPUIF;
      dec_o.slot = 3'(page - 4'd1);
    end else if (page >= TMR_FIRST && page <= TMR_LAST) begin
      dec_o.slot = 3'(page - TMR_FIRST);
      if (sub == 3'd0)      dec_o.tgt = TGT_TIMER;
      else if (sub == 3'd1) dec_o.tgt = TGT_WDOG;
    end
  end
endmodule

// File: rtl/smp_scu_regs.sv
module smp_scu_regs
  import smp_priv_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          write_i,
  input  logic [5:0]    word_i,
  input  logic          wbit_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  localparam logic [DW-1:0] CFG = cfg_value(NUM_CPU);
  localparam logic [5:0] W_CTRL = 6'd0, W_CFG = 6'd1, W_STAT = 6'd2, W_INV = 6'd3;

  logic ctrl_q;

  always_comb begin
    rdata_o = '0;
    err_o   = 1'b0;
    unique case (word_i)
      W_CTRL: rdata_o[0] = ctrl_q;
      W_CFG:  begin rdata_o = CFG; err_o = write_i; end
      W_STAT: err_o = write_i;
      W_INV:  ;
      default: err_o = 1'b1;
    endcase
    if (err_o) rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_q <= 1'b0;
    else if (acc_i && write_i && word_i == W_CTRL) ctrl_q <= wbit_i;
  end
endmodule

// File: rtl/smp_priv_decode.sv
module smp_priv_decode
  import smp_priv_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [12:0]       req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              sel_scu_o,
  output logic [NUM_CPU:0]  sel_cpuif_o,
  output logic [NUM_CPU:0]  sel_timer_o,
  output logic [NUM_CPU:0]  sel_wdog_o,
  output logic              sel_dist_o
);
  localparam int unsigned SLOTS = NUM_CPU + 1;

  dec_t          dec;
  logic [DW-1:0] scu_rdata;
  logic          scu_err;
  logic          is_scu, local_acc, acc_err;

  smp_addr_decode #(.NUM_CPU(NUM_CPU)) i_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  assign is_scu = req_valid_i && dec.tgt == TGT_SCU;

  smp_scu_regs #(.NUM_CPU(NUM_CPU)) i_scu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (is_scu),
    .write_i (req_write_i),
    .word_i  (req_addr_i[7:2]),
    .wbit_i  (req_wdata_i[0]),
    .rdata_o (scu_rdata),
    .err_o   (scu_err)
  );

  assign req_ready_o = 1'b1;
  assign acc_err   = dec.tgt == TGT_ERR || (dec.tgt == TGT_SCU && scu_err);
  assign local_acc = dec.tgt == TGT_ERR || dec.tgt == TGT_SCU;

  assign sel_scu_o  = is_scu && !scu_err;
  assign sel_dist_o = req_valid_i && dec.tgt == TGT_DIST;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = req_valid_i && dec.slot == 3'(s);
    assign sel_cpuif_o[s] = hit && dec.tgt == TGT_CPUIF;
    assign sel_timer_o[s] = hit && dec.tgt == TGT_TIMER;
    assign sel_wdog_o[s]  = hit && dec.tgt == TGT_WDOG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i && local_acc;
      if (req_valid_i && local_acc) begin
        rsp_err_o   <= acc_err;
        rsp_rdata_o <= acc_err ? '0 : scu_rdata;
      end
    end
  end
endmodule

// File: rtl/smp_priv_decode_chk.sv
module smp_priv_decode_chk #(
  parameter int unsigned NUM_CPU = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [12:0]       req_addr_i,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              sel_scu_o,
  input logic [NUM_CPU:0]  sel_cpuif_o,
  input logic [NUM_CPU:0]  sel_timer_o,
  input logic [NUM_CPU:0]  sel_wdog_o,
  input logic              sel_dist_o
);
  logic [3*NUM_CPU+4:0] all_sel;
  assign all_sel = {sel_scu_o, sel_cpuif_o, sel_timer_o, sel_wdog_o, sel_dist_o};

  a_r10_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(all_sel));
  a_r10_sel_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> all_sel == '0);
  a_r10_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o);
  a_r10_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i));
  a_r5_err_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);
  a_r8_dist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[12] |-> sel_dist_o);
  a_r2_ctrl_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_err_o && $past(req_addr_i[12:2]) == '0 |-> rsp_rdata_o[31:1] == '0);
  a_r9_err_is_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && all_sel == '0 |=> rsp_valid_o && rsp_err_o);
endmodule

bind smp_priv_decode smp_priv_decode_chk #(.NUM_CPU(NUM_CPU)) i_chk (.*);

// File: tb/test_smp_priv_decode.sv
module test_smp_priv_decode;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, sel_scu, sel_dist;
  logic [31:0] rsp_rdata;
  logic [N:0] sel_cpuif, sel_timer, sel_wdog;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smp_priv_decode #(.NUM_CPU(N)) i_smp_priv_decode (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .sel_scu_o(sel_scu), .sel_cpuif_o(sel_cpuif), .sel_timer_o(sel_timer),
    .sel_wdog_o(sel_wdog), .sel_dist_o(sel_dist)
  );

  // captured per access
  logic [3*N+4:0] s_sel;
  logic s_rv, s_err;
  logic [31:0] s_data;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1 s_sel = {sel_scu, sel_cpuif, sel_timer, sel_wdog, sel_dist};
    @(posedge clk); #1;
    req_valid = 1'b0;
    s_rv = rsp_valid; s_err = rsp_err; s_data = rsp_rdata;
  endtask

  function automatic logic [3*N+4:0] vec(int grp, int slot);
    logic [3*N+4:0] v = '0;
    case (grp)
      0: v[3*N+4] = 1'b1;
      1: v[2*N+3+slot] = 1'b1;
      2: v[N+2+slot] = 1'b1;
      3: v[1+slot] = 1'b1;
      default: v[0] = 1'b1;
    endcase
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    access(0, 13'h000, 0);
    chk("R1 ctrl", 64'(s_data), 0);
    chk("R10 ready", 64'(req_ready), 1);
  endtask

  task automatic t_ctrl();
    access(1, 13'h000, 32'hFFFF_FFFE);
    access(0, 13'h000, 0);
    chk("R2 bit0 clear", 64'(s_data), 0);
    access(1, 13'h000, 32'hA5A5_0005);
    chk("R10 write rsp", 64'({s_rv, s_err}), 64'b10);
    access(0, 13'h000, 0);
    chk("R2 bit0 kept", 64'(s_data), 1);
    chk("R10 scu sel", 64'(s_sel), 64'(vec(0, 0)));
  endtask

  task automatic t_cfg_status();
    access(0, 13'h004, 0);
    chk("R3 config", 64'({s_err, s_data}), 64'h0F3);
    access(0, 13'h008, 0);
    chk("R4 status", 64'({s_err, s_data}), 0);
    access(0, 13'h00C, 0);
    chk("R4 inval read", 64'({s_err, s_data}), 0);
    access(1, 13'h00C, 0);
    chk("R4 inval write no err", 64'({s_rv, s_err}), 64'b10);
    access(0, 13'h000, 0);
    chk("R4 ctrl untouched", 64'(s_data), 1);
  endtask

  task automatic t_errors();
    access(1, 13'h004, 0);
    chk("R5 cfg write err", 64'({s_rv, s_err, s_sel}), 64'({2'b11, 17'b0}));
    access(1, 13'h008, 0);
    chk("R5 status write err", 64'({s_rv, s_err}), 64'b11);
    access(0, 13'h004, 0);
    chk("R5 cfg unchanged", 64'(s_data), 64'h0F3);
    access(0, 13'h010, 0);
    chk("R5 bad offset", 64'({s_err, s_data}), 64'h1_0000_0000);
    access(1, 13'h0FC, 0);
    access(0, 13'h000, 0);
    chk("R5 ctrl unchanged", 64'(s_data), 1);
  endtask

  task automatic t_cpuif();
    access(0, 13'h100, 0);
    chk("R6 alias", 64'(s_sel), 64'(vec(1, 0)));
    chk("R10 no local rsp", 64'(s_rv), 0);
    access(1, 13'h1FC, 0);
    chk("R6 alias top", 64'(s_sel), 64'(vec(1, 0)));
    access(0, 13'h300, 0);
    chk("R6 cpu1", 64'(s_sel), 64'(vec(1, 2)));
    access(0, 13'h5F0, 0);
    chk("R6 cpu3", 64'(s_sel), 64'(vec(1, 4)));
  endtask

  task automatic t_timers();
    access(0, 13'h600, 0);
    chk("R7 timer alias", 64'(s_sel), 64'(vec(2, 0)));
    access(0, 13'h71C, 0);
    chk("R7 timer cpu0", 64'(s_sel), 64'(vec(2, 1)));
    access(0, 13'h920, 0);
    chk("R7 wdog cpu2", 64'(s_sel), 64'(vec(3, 3)));
    access(0, 13'hA3C, 0);
    chk("R7 wdog cpu3", 64'(s_sel), 64'(vec(3, 4)));
    access(0, 13'h640, 0);
    chk("R7 hole err", 64'({s_rv, s_err, s_sel}), 64'({2'b11, 17'b0}));
  endtask

  task automatic t_dist_unpop();
    access(0, 13'h1000, 0);
    chk("R8 dist low", 64'(s_sel), 64'(vec(4, 0)));
    access(1, 13'h1FFC, 0);
    chk("R8 dist high", 64'({s_rv, s_sel}), 64'(vec(4, 0)));
    access(0, 13'hB00, 0);
    chk("R9 page B err", 64'({s_rv, s_err, s_data, s_sel}), 64'({2'b11, 32'b0, 17'b0}));
    access(0, 13'hFFC, 0);
    chk("R9 page F err", 64'({s_rv, s_err, s_sel}), 64'({2'b11, 17'b0}));
    @(negedge clk);
    chk("R10 idle no sel", 64'({sel_scu, sel_cpuif, sel_timer, sel_wdog, sel_dist}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_cfg_status();
    t_errors();
    t_cpuif();
    t_timers();
    t_dist_unpop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule